// File: doc/BRIEF.md
# Shared-Line Interrupt Router

This block takes eight level-sensitive shared interrupt inputs and one power-management (SCI) level input. It drives two sets of outputs: sixteen lines toward a legacy 8259-style controller, and twenty-four global system interrupt (GSI) lines toward an I/O APIC. Eight route bytes, one for each input, tell the block which legacy line each input joins, or that the input must stay off the legacy side. A control byte picks the line that carries the SCI.

On the legacy side, each output line is the OR of every input whose route is enabled and points at that line, plus the SCI when the SCI is selected there. On the APIC side, input n always drives GSI 16+n, and no other input shares that GSI. The SCI is also ORed into the GSI that has its number. A query port takes an input index and returns where that input is delivered: legacy, APIC, or nowhere. Each write to a route byte raises a one-cycle notification so that neighbouring logic can refresh its cached routing.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset, route bytes 0..7 read back 0x80 and the control byte (address 8) reads 0x00. All legacy and GSI outputs are low, and route_chg_o is low.
- R2: Route byte n (address n) holds the target line in bits 4:0 and a disable flag in bit 7. Legacy line k is the OR of every input n whose bit 7 is clear and whose bits 4:0 equal k.
- R3: An enabled route whose target is 16 or more drives no legacy line.
- R4: Input n drives GSI 16+n whatever its route byte holds. GSIs 0..15 carry no input level.
- R5: Control bits 2:0 select the SCI line: 0 gives 9, 1 gives 10, 2 gives 11, 3 gives 20, 4 gives 21, and 5..7 route the SCI nowhere. The SCI is ORed into the selected GSI. When the selected line is below 16, it is also ORed into that legacy line.
- R6: The query returns, one cycle after qry_sel_i is presented, kind 1 (APIC) with number 16+n when bit 7 is set. It returns kind 0 (legacy) with the target number when the target is below 16. Otherwise it returns kind 2 (dropped) with number 0.
- R7: route_chg_o is high for exactly the cycle after a write to addresses 0..7, and stays low after a write to any other address.
- R8: Every legacy and GSI output is registered. An input change shows at the outputs after exactly one rising clock edge.
- R9: Writes to addresses 9..15 change no state and those addresses read 0. Reads are registered and return one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pci_int_i | input | 8 | Shared interrupt input levels |
| sci_i | input | 1 | SCI level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Registered read data |
| route_chg_o | output | 1 | Routing-changed pulse |
| legacy_irq_o | output | 16 | Legacy controller lines |
| gsi_o | output | 24 | APIC lines |
| qry_sel_i | input | 3 | Input index to query |
| qry_kind_o | output | 2 | 0 legacy, 1 APIC, 2 dropped |
| qry_irq_o | output | 5 | Line number of the queried route |

## Verification
A write lands on one rising edge. The outputs that depend on the new byte are valid after the next edge. So the bench changes inputs at a falling edge and samples one falling edge later for a level or query change, and two falling edges later after a register write. route_chg_o is sampled at the falling edge that follows the write edge. For latency, the bench also samples just after the input changes, before any edge, and expects the old value there, which pins R8 to exactly one edge.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    ROUTE_LEGACY = 2'd0,
    ROUTE_APIC   = 2'd1,
    ROUTE_NONE   = 2'd2
  } route_kind_e;

  // Returns {valid, line number} for the SCI select code.
  function automatic logic [5:0] sci_decode(input logic [2:0] code);
    case (code)
      3'd0:    return {1'b1, 5'd9};
      3'd1:    return {1'b1, 5'd10};
      3'd2:    return {1'b1, 5'd11};
      3'd3:    return {1'b1, 5'd20};
      3'd4:    return {1'b1, 5'd21};
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NPIN      = 8,
  parameter int AW        = 4,
  parameter logic [7:0] ROUTE_RST = 8'h80,
  parameter logic [7:0] CTRL_RST  = 8'h00
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [7:0]                wdata_i,
  output logic [NPIN-1:0][7:0]      route_o,
  output logic [7:0]                ctrl_o,
  output logic [7:0]                rdata_o,
  output logic                      chg_o
);
  localparam int IW = $clog2(NPIN);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NPIN);

  logic hit_route;
  assign hit_route = (addr_i < CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPIN; i++) route_o[i] <= ROUTE_RST;
      ctrl_o  <= CTRL_RST;
      rdata_o <= 8'h00;
      chg_o   <= 1'b0;
    end else begin
      chg_o <= we_i && hit_route;
      if (we_i) begin
        if (hit_route) route_o[addr_i[IW-1:0]] <= wdata_i;
        else if (addr_i == CTRL_ADDR) ctrl_o <= wdata_i;
      end
      if (hit_route)               rdata_o <= route_o[addr_i[IW-1:0]];
      else if (addr_i == CTRL_ADDR) rdata_o <= ctrl_o;
      else                          rdata_o <= 8'h00;
    end
  end

  // R7
  route_chg_src_chk: assert property (@(posedge clk) disable iff (rst)
    chg_o |-> $past(we_i && (addr_i < CTRL_ADDR)));
endmodule

// File: rtl/irq_legacy_or.sv
module irq_legacy_or #(
  parameter int NPIN    = 8,
  parameter int NLEG    = 16,
  parameter int FLD_W   = 5,
  parameter int DIS_BIT = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPIN-1:0]      pin_i,
  input  logic                 sci_i,
  input  logic [NLEG-1:0]      sci_map_i,
  input  logic [NPIN-1:0][7:0] route_i,
  output logic [NLEG-1:0]      legacy_o
);
  logic [NLEG-1:0] nxt;

  always_comb begin
    for (int k = 0; k < NLEG; k++) begin
      nxt[k] = sci_i & sci_map_i[k];
      for (int n = 0; n < NPIN; n++) begin
        if (!route_i[n][DIS_BIT] && (route_i[n][FLD_W-1:0] == FLD_W'(k)))
          nxt[k] = nxt[k] | pin_i[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) legacy_o <= '0;
    else     legacy_o <= nxt;
  end

  // R2
  legacy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_i == '0 && !sci_i) |=> (legacy_o == '0));
endmodule

// File: rtl/irq_apic_map.sv
module irq_apic_map #(
  parameter int NPIN     = 8,
  parameter int NGSI     = 24,
  parameter int GSI_BASE = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic            sci_i,
  input  logic [NGSI-1:0] sci_map_i,
  output logic [NGSI-1:0] gsi_o
);
  logic [NGSI-1:0] nxt;

  always_comb begin
    nxt = sci_i ? sci_map_i : '0;
    for (int n = 0; n < NPIN; n++)
      nxt[GSI_BASE+n] = nxt[GSI_BASE+n] | pin_i[n];
  end

  always_ff @(posedge clk) begin
    if (rst) gsi_o <= '0;
    else     gsi_o <= nxt;
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_pin_chk
    // R4 / R8
    gsi_follow_chk: assert property (@(posedge clk) disable iff (rst)
      pin_i[n] |=> gsi_o[GSI_BASE+n]);
  end

  // R5
  sci_single_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sci_map_i));

  // R5
  gsi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_i == '0 && !sci_i) |=> (gsi_o == '0));
endmodule

// File: rtl/irq_route_query.sv
module irq_route_query
  import irq_router_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int NLEG     = 16,
  parameter int GSI_BASE = 16,
  parameter int FLD_W    = 5,
  parameter int DIS_BIT  = 7,
  parameter int GW       = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(NPIN)-1:0]   sel_i,
  input  logic [NPIN-1:0][7:0]      route_i,
  output route_kind_e               kind_o,
  output logic [GW-1:0]             irq_o
);
  logic [7:0] rb;
  assign rb = route_i[sel_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_o <= ROUTE_NONE;
      irq_o  <= '0;
    end else if (rb[DIS_BIT]) begin
      kind_o <= ROUTE_APIC;
      irq_o  <= GW'(GSI_BASE) + GW'(sel_i);
    end else if (32'(rb[FLD_W-1:0]) < NLEG) begin
      kind_o <= ROUTE_LEGACY;
      irq_o  <= GW'(rb[FLD_W-1:0]);
    end else begin
      kind_o <= ROUTE_NONE;
      irq_o  <= '0;
    end
  end

  // R6
  query_apic_range_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_o == ROUTE_APIC) |-> (32'(irq_o) >= GSI_BASE));

  // R6
  query_none_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_o == ROUTE_NONE) |-> (irq_o == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int NLEG     = 16,
  parameter int NGSI     = 24,
  parameter int FLD_W    = 5,
  parameter int DIS_BIT  = 7,
  parameter int AW       = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPIN-1:0]          pci_int_i,
  input  logic                     sci_i,
  input  logic                     cfg_we_i,
  input  logic [AW-1:0]            cfg_addr_i,
  input  logic [7:0]               cfg_wdata_i,
  output logic [7:0]               cfg_rdata_o,
  output logic                     route_chg_o,
  output logic [NLEG-1:0]          legacy_irq_o,
  output logic [NGSI-1:0]          gsi_o,
  input  logic [$clog2(NPIN)-1:0]  qry_sel_i,
  output logic [1:0]               qry_kind_o,
  output logic [$clog2(NGSI)-1:0]  qry_irq_o
);
  localparam int GSI_BASE = NLEG;
  localparam int GW       = $clog2(NGSI);

  logic [NPIN-1:0][7:0] route;
  logic [7:0]           ctrl;
  logic [5:0]           sci_dec;
  logic [NGSI-1:0]      sci_map;
  route_kind_e          kind;

  always_comb begin
    sci_dec = sci_decode(ctrl[2:0]);
    sci_map = '0;
    if (sci_dec[5] && 32'(sci_dec[4:0]) < NGSI) sci_map[sci_dec[4:0]] = 1'b1;
  end

  irq_route_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .route_o(route), .ctrl_o(ctrl),
    .rdata_o(cfg_rdata_o), .chg_o(route_chg_o)
  );

  irq_legacy_or #(.NPIN(NPIN), .NLEG(NLEG), .FLD_W(FLD_W), .DIS_BIT(DIS_BIT)) u_leg (
    .clk(clk), .rst(rst), .pin_i(pci_int_i), .sci_i(sci_i),
    .sci_map_i(sci_map[NLEG-1:0]), .route_i(route), .legacy_o(legacy_irq_o)
  );

  irq_apic_map #(.NPIN(NPIN), .NGSI(NGSI), .GSI_BASE(GSI_BASE)) u_apic (
    .clk(clk), .rst(rst), .pin_i(pci_int_i), .sci_i(sci_i),
    .sci_map_i(sci_map), .gsi_o(gsi_o)
  );

  irq_route_query #(.NPIN(NPIN), .NLEG(NLEG), .GSI_BASE(GSI_BASE),
                    .FLD_W(FLD_W), .DIS_BIT(DIS_BIT), .GW(GW)) u_qry (
    .clk(clk), .rst(rst), .sel_i(qry_sel_i), .route_i(route),
    .kind_o(kind), .irq_o(qry_irq_o)
  );

  assign qry_kind_o = kind;
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pci_int = '0;
  logic        sci = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        chg;
  logic [15:0] leg;
  logic [23:0] gsi;
  logic [2:0]  qsel = '0;
  logic [1:0]  qkind;
  logic [4:0]  qirq;

  int checks = 0;
  int errors = 0;
  logic [7:0] rt [8];
  logic [7:0] ctl;

  always #10 clk = ~clk;

  irq_router u_irq_router (
    .clk(clk), .rst(rst), .pci_int_i(pci_int), .sci_i(sci),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .route_chg_o(chg), .legacy_irq_o(leg),
    .gsi_o(gsi), .qry_sel_i(qsel), .qry_kind_o(qkind), .qry_irq_o(qirq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int sci_line(input logic [2:0] c);
    case (c)
      3'd0: return 9;   3'd1: return 10;  3'd2: return 11;
      3'd3: return 20;  3'd4: return 21;  default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_leg(input logic [7:0] p, input logic s);
    logic [15:0] v = '0;
    int sl = sci_line(ctl[2:0]);
    for (int n = 0; n < 8; n++)
      if (!rt[n][7] && rt[n][4:0] < 16 && p[n]) v[rt[n][3:0]] = 1'b1;
    if (s && sl >= 0 && sl < 16) v[sl] = 1'b1;
    return v;
  endfunction

  function automatic logic [23:0] exp_gsi(input logic [7:0] p, input logic s);
    logic [23:0] v = {p, 16'h0};
    int sl = sci_line(ctl[2:0]);
    if (s && sl >= 0) v[sl] = 1'b1;
    return v;
  endfunction

  // write; returns at the falling edge after the write edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a < 8) rt[a] = d;
    else if (a == 8) ctl = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 8; i++) rt[i] = 8'h80;
    ctl = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 legacy", leg, 0);
    check("R1 gsi", gsi, 0);
    check("R1 chg", chg, 0);
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], d);
      check("R1 readback", d, (a < 8) ? 8'h80 : 8'h00);
    end

    // R2 R3 R4 R6 R7: sweep each input over every target and both disable states
    for (int n = 0; n < 8; n++) begin
      for (int t = 0; t < 32; t++) begin
        for (int ds = 0; ds < 2; ds++) begin
          wr(n[3:0], {ds[0], 2'b00, t[4:0]});
          check("R7 chg after route write", chg, 1);
          pci_int = 8'(1 << n);
          qsel = n[2:0];
          @(negedge clk);
          check("R2 R3 legacy", leg, exp_leg(pci_int, 1'b0));
          check("R4 gsi", gsi, exp_gsi(pci_int, 1'b0));
          if (ds == 1) begin
            check("R6 kind apic", qkind, 1); check("R6 irq apic", qirq, 16 + n);
          end else if (t < 16) begin
            check("R6 kind legacy", qkind, 0); check("R6 irq legacy", qirq, t);
          end else begin
            check("R6 kind dropped", qkind, 2); check("R6 irq dropped", qirq, 0);
          end
          pci_int = '0;
        end
      end
      wr(n[3:0], 8'h80);
    end

    // R2 sharing: all inputs on line 5 except 2 on line 5 disabled, 6 on 12
    for (int n = 0; n < 8; n++) wr(n[3:0], 8'h05);
    wr(4'd2, 8'h85);
    wr(4'd6, 8'h0C);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      pci_int = p[7:0];
      @(negedge clk);
      check("R2 shared line", leg, exp_leg(pci_int, 1'b0));
      check("R4 gsi shared", gsi, exp_gsi(pci_int, 1'b0));
    end
    pci_int = '0;

    // R5 SCI select sweep, with and without input 4 sharing GSI 20 / legacy 9
    wr(4'd4, 8'h09);
    for (int c = 0; c < 8; c++) begin
      wr(4'd8, 8'(c));
      check("R7 no chg on control write", chg, 0);
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        sci = s[0]; pci_int = s[1] ? 8'h10 : 8'h00;
        @(negedge clk);
        check("R5 sci legacy", leg, exp_leg(pci_int, sci));
        check("R5 sci gsi", gsi, exp_gsi(pci_int, sci));
      end
    end
    sci = 1'b0; pci_int = '0;

    // R8 exact one-edge latency
    @(negedge clk);
    pci_int = 8'h10;
    #2;
    check("R8 before edge legacy", leg[9], 0);
    check("R8 before edge gsi", gsi[20], 0);
    @(negedge clk);
    check("R8 after edge legacy", leg[9], 1);
    check("R8 after edge gsi", gsi[20], 1);
    pci_int = '0;
    @(negedge clk);

    // R9 writes above the control byte are ignored
    for (int a = 9; a < 16; a++) begin
      wr(a[3:0], 8'hFF);
      check("R9 no chg", chg, 0);
      rd(a[3:0], d);
      check("R9 reads zero", d, 0);
    end
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], d);
      check("R9 state kept", d, (a < 8) ? rt[a] : ctl);
    end
    @(negedge clk);
    pci_int = 8'hFF;
    @(negedge clk);
    check("R9 legacy unchanged", leg, exp_leg(pci_int, 1'b0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule